// File: doc/BRIEF.md
# Free-Running Timer with Compare Flags

This block is a 16-bit up-counter that runs without stopping from a prescaled system clock. It carries two compare channels and an overflow detector, and it is reached through a byte-wide register port. A mode register picks the prescale ratio, or stops the counter. It also connects each compare channel's output level to its pin. A read-only status byte gathers the two match flags and the overflow flag.

Software clears the flags with a fixed handshake. It first reads the status byte while the flag is set, then reads or writes the low byte of the 16-bit register tied to that flag. A match or a rollover that lands on the same clock edge as the clearing access wins, so no event is lost. The counter's high byte snapshots its low byte when read, so software reads a coherent 16-bit value in two steps. A second, side-effect-free view of the counter serves code that must not disturb the overflow flag.

Registers (4-bit address, 8-bit data): 0 level bits, 1 mode, 2 status, 3/4 counter high/low, 5/6 quiet counter view high/low, 7/8 compare-1 high/low, 9/10 compare-2 high/low.

Top module: `frt_timer`

## Requirements
- R1: The mode register (address 1) resets to 00h. Bit 7 enables the channel-1 pin, bit 6 enables the channel-2 pin and bits 3:2 are the clock select. Bits 5:4 and 1:0 always read 0, so writing FFh reads back CCh.
- R2: With clock select 00 the counter advances once per 4 clocks, with 01 once per 2 and with 10 once per 8. With 11 the counter holds its value and the prescaler is kept at zero.
- R3: The status register (address 2) resets to 00h and ignores writes. Bit 6 is the channel-1 match flag, bit 5 the overflow flag and bit 3 the channel-2 match flag. Bits 7, 4 and 2:0 always read 0.
- R4: The counter resets to the parameter CNT_RST. The overflow flag sets on the step from FFFFh to 0000h.
- R5: A channel's match flag sets when the counter steps onto the value of that channel's compare register (reset FFFFh). This happens whatever the pin enables are.
- R6: A flag clears only after two steps. First a status read sees it at 1. Then comes a read or write of its low byte: address 4 for overflow, 8 for channel 1, 10 for channel 2. Such an access without the earlier status read, or an access to another low byte, leaves the flag set.
- R7: Reading the quiet low byte (address 6) never clears the overflow flag, even after a status read.
- R8: Reading the counter high byte (address 3 or 5) captures the low byte. The next low-byte read (address 4 or 6) returns that captured value instead of the live count.
- R9: On each match a channel's output level takes that channel's bit from the level register (address 0: bit 0 for channel 1, bit 1 for channel 2). Levels and the level register reset to 0.
- R10: Each compare pin shows its channel's output level while its enable bit is 1, and is 0 while the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Single-cycle read strobe; side effects act on this cycle's edge |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| oc1_pin | output | 1 | Channel-1 compare pin |
| oc2_pin | output | 1 | Channel-2 compare pin |

## Verification
A wrong prescaler phase or divide ratio shows as a counter low byte that is off from k/D within one divide period of the mode write. The bench sweeps every idle length from 0 to 17 for each ratio. A stuck or wrongly armed flag shows on the very next status read, so every handshake step is followed at once by a status read. A bad snapshot or a wrong level bit shows on the next low-byte read or at the pin one clock after the match edge.

// File: rtl/frt_pkg.sv
package frt_pkg;

  typedef enum logic [3:0] {
    A_LVL    = 4'h0,
    A_MODE   = 4'h1,
    A_STS    = 4'h2,
    A_CNT_HI = 4'h3,
    A_CNT_LO = 4'h4,
    A_ALT_HI = 4'h5,
    A_ALT_LO = 4'h6,
    A_C1_HI  = 4'h7,
    A_C1_LO  = 4'h8,
    A_C2_HI  = 4'h9,
    A_C2_LO  = 4'hA
  } reg_addr_e;

  localparam int unsigned N_CMP   = 2;
  localparam int unsigned N_FLAG  = 3;
  localparam int unsigned PRE_W   = 3;

  // flag slot indices
  localparam int unsigned F_OVF = 0;
  localparam int unsigned F_C1  = 1;
  localparam int unsigned F_C2  = 2;

  // status bit positions
  localparam int unsigned S_C1  = 6;
  localparam int unsigned S_OVF = 5;
  localparam int unsigned S_C2  = 3;

  // mode bit positions
  localparam int unsigned M_EN1 = 7;
  localparam int unsigned M_EN2 = 6;
  localparam int unsigned M_SEL = 2;

  // divide ratio for a clock select value, 0 = stopped
  function automatic logic [PRE_W:0] div_of(input logic [1:0] sel);
    case (sel)
      2'b00:   div_of = 4'd4;
      2'b01:   div_of = 4'd2;
      2'b10:   div_of = 4'd8;
      default: div_of = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/frt_count_core.sv
module frt_count_core
  import frt_pkg::*;
#(
  parameter int unsigned          CNT_W   = 16,
  parameter logic [CNT_W-1:0]     CNT_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       clk_sel,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             tick_o,
  output logic             wrap_o
);

  logic [PRE_W-1:0] presc_q, presc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [PRE_W:0]   div;
  logic             run, tick;

  always_comb begin
    div     = div_of(clk_sel);
    run     = (div != '0);
    tick    = run && ({1'b0, presc_q} >= (div - 1'b1));
    presc_d = presc_q;
    if (!run)       presc_d = '0;
    else if (tick)  presc_d = '0;
    else            presc_d = presc_q + 1'b1;
    cnt_inc = cnt_q + 1'b1;
    cnt_d   = tick ? cnt_inc : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= CNT_RST;
    end else begin
      presc_q <= presc_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_inc;
  assign tick_o    = tick;
  assign wrap_o    = tick && (cnt_q == '1);

endmodule

// File: rtl/frt_flag_cell.sv
module frt_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic sts_rd_i,
  input  logic clr_acc_i,
  output logic flag_o
);

  logic flag_q, flag_d, arm_q, arm_d, do_clr;

  always_comb begin
    do_clr = clr_acc_i && arm_q;
    // a new event outranks the clearing access
    flag_d = set_i || (flag_q && !do_clr);
    arm_d  = arm_q;
    if (do_clr)                    arm_d = 1'b0;
    else if (sts_rd_i && flag_q)   arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/frt_cmp_chan.sv
module frt_cmp_chan #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  input  logic              lvl_bit_i,
  input  logic              pin_en_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              match_o,
  output logic              pin_o
);

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             lvl_q, lvl_d, match;

  always_comb begin
    cmp_d = cmp_q;
    if (wr_hi_i) cmp_d[CNT_W-1:DATA_W] = wdata_i;
    if (wr_lo_i) cmp_d[DATA_W-1:0]     = wdata_i;
    match = tick_i && (cnt_nxt_i == cmp_q);
    lvl_d = match ? lvl_bit_i : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      lvl_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      lvl_q <= lvl_d;
    end
  end

  assign cmp_o   = cmp_q;
  assign match_o = match;
  assign pin_o   = lvl_q && pin_en_i;

endmodule

// File: rtl/frt_timer.sv
module frt_timer
  import frt_pkg::*;
#(
  parameter int unsigned            DATA_W  = 8,
  parameter logic [2*DATA_W-1:0]    CNT_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              oc1_pin,
  output logic              oc2_pin
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  // access decode
  logic acc, rd_sts, rd_hi, rd_lo;
  logic wr_mode, wr_lvl;

  always_comb begin
    acc     = bus_rd || bus_wr;
    rd_sts  = bus_rd && (bus_addr == A_STS);
    rd_hi   = bus_rd && ((bus_addr == A_CNT_HI) || (bus_addr == A_ALT_HI));
    rd_lo   = bus_rd && ((bus_addr == A_CNT_LO) || (bus_addr == A_ALT_LO));
    wr_mode = bus_wr && (bus_addr == A_MODE);
    wr_lvl  = bus_wr && (bus_addr == A_LVL);
  end

  // mode, level and snapshot registers
  logic [N_CMP-1:0]  en_q, en_d, lvl_q, lvl_d;
  logic [1:0]        sel_q, sel_d;
  logic [DATA_W-1:0] snap_q, snap_d;
  logic              held_q, held_d;
  logic [CNT_W-1:0]  cnt_w, cnt_nxt_w;
  logic              tick_w, wrap_w;

  always_comb begin
    en_d   = en_q;
    sel_d  = sel_q;
    lvl_d  = lvl_q;
    snap_d = snap_q;
    held_d = held_q;
    if (wr_mode) begin
      en_d  = {bus_wdata[M_EN2], bus_wdata[M_EN1]};
      sel_d = bus_wdata[M_SEL +: 2];
    end
    if (wr_lvl) lvl_d = bus_wdata[N_CMP-1:0];
    if (rd_hi) begin
      snap_d = cnt_w[DATA_W-1:0];
      held_d = 1'b1;
    end else if (rd_lo) begin
      held_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      en_q   <= '0;
      sel_q  <= '0;
      lvl_q  <= '0;
      snap_q <= '0;
      held_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      lvl_q  <= lvl_d;
      snap_q <= snap_d;
      held_q <= held_d;
    end
  end

  // counter with prescaler
  frt_count_core #(
    .CNT_W   (CNT_W),
    .CNT_RST (CNT_RST)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clk_sel   (sel_q),
    .cnt_o     (cnt_w),
    .cnt_nxt_o (cnt_nxt_w),
    .tick_o    (tick_w),
    .wrap_o    (wrap_w)
  );

  // compare channels
  logic [CNT_W-1:0] cmp_val [N_CMP];
  logic [N_CMP-1:0] match_v, pin_v;

  for (genvar g = 0; g < N_CMP; g++) begin : g_chan
    localparam logic [3:0] HI_A = (g == 0) ? A_C1_HI : A_C2_HI;
    localparam logic [3:0] LO_A = (g == 0) ? A_C1_LO : A_C2_LO;
    frt_cmp_chan #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .wr_hi_i   (bus_wr && (bus_addr == HI_A)),
      .wr_lo_i   (bus_wr && (bus_addr == LO_A)),
      .wdata_i   (bus_wdata),
      .tick_i    (tick_w),
      .cnt_nxt_i (cnt_nxt_w),
      .lvl_bit_i (lvl_q[g]),
      .pin_en_i  (en_q[g]),
      .cmp_o     (cmp_val[g]),
      .match_o   (match_v[g]),
      .pin_o     (pin_v[g])
    );
  end

  // flags: overflow, channel 1, channel 2
  logic [N_FLAG-1:0] set_v, clr_v, flag_v;

  always_comb begin
    set_v[F_OVF] = wrap_w;
    set_v[F_C1]  = match_v[0];
    set_v[F_C2]  = match_v[1];
    clr_v[F_OVF] = acc && (bus_addr == A_CNT_LO);
    clr_v[F_C1]  = acc && (bus_addr == A_C1_LO);
    clr_v[F_C2]  = acc && (bus_addr == A_C2_LO);
  end

  for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
    frt_flag_cell u_flag (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .set_i     (set_v[f]),
      .sts_rd_i  (rd_sts),
      .clr_acc_i (clr_v[f]),
      .flag_o    (flag_v[f])
    );
  end

  // combinational read mux
  logic [DATA_W-1:0] sts_byte, mode_byte, lo_byte;

  always_comb begin
    sts_byte        = '0;
    sts_byte[S_C1]  = flag_v[F_C1];
    sts_byte[S_OVF] = flag_v[F_OVF];
    sts_byte[S_C2]  = flag_v[F_C2];
    mode_byte           = '0;
    mode_byte[M_EN1]    = en_q[0];
    mode_byte[M_EN2]    = en_q[1];
    mode_byte[M_SEL+:2] = sel_q;
    lo_byte = held_q ? snap_q : cnt_w[DATA_W-1:0];
    bus_rdata = '0;
    case (bus_addr)
      A_LVL:               bus_rdata[N_CMP-1:0] = lvl_q;
      A_MODE:              bus_rdata = mode_byte;
      A_STS:               bus_rdata = sts_byte;
      A_CNT_HI, A_ALT_HI:  bus_rdata = cnt_w[CNT_W-1:DATA_W];
      A_CNT_LO, A_ALT_LO:  bus_rdata = lo_byte;
      A_C1_HI:             bus_rdata = cmp_val[0][CNT_W-1:DATA_W];
      A_C1_LO:             bus_rdata = cmp_val[0][DATA_W-1:0];
      A_C2_HI:             bus_rdata = cmp_val[1][CNT_W-1:DATA_W];
      A_C2_LO:             bus_rdata = cmp_val[1][DATA_W-1:0];
      default:             bus_rdata = '0;
    endcase
  end

  assign oc1_pin = pin_v[0];
  assign oc2_pin = pin_v[1];

endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp1,
  input logic [1:0]        sel,
  input logic [1:0]        en,
  input logic              pin1,
  input logic              pin2,
  input logic              f_ovf,
  input logic              f_c1
);

  AST_PIN1_GATED: assert property (@(posedge clk) disable iff (!rst_n) !en[0] |-> !pin1); // R10
  AST_PIN2_GATED: assert property (@(posedge clk) disable iff (!rst_n) !en[1] |-> !pin2); // R10
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1)); // R2
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sel == 2'b11) |=> (cnt == $past(cnt))); // R2
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n) ((cnt == '0) && ($past(cnt) == '1)) |-> f_ovf); // R4
  AST_CMP1_SET: assert property (@(posedge clk) disable iff (!rst_n) ((cnt != $past(cnt)) && (cnt == $past(cmp1))) |-> f_c1); // R5
  AST_OVF_CLR_PATH: assert property (@(posedge clk) disable iff (!rst_n) $fell(f_ovf) |-> $past((bus_rd || bus_wr) && (bus_addr == 4'h4))); // R6
  AST_ALT_NOCLR: assert property (@(posedge clk) disable iff (!rst_n) (f_ovf && bus_rd && (bus_addr == 4'h6)) |=> f_ovf); // R7
  AST_STS_RSVD: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && (bus_addr == 4'h2)) |-> ((bus_rdata & 8'h97) == 8'h00)); // R3

endmodule

bind frt_timer frt_timer_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .cnt       (cnt_w),
  .cmp1      (cmp_val[0]),
  .sel       (sel_q),
  .en        (en_q),
  .pin1      (oc1_pin),
  .pin2      (oc2_pin),
  .f_ovf     (flag_v[0]),
  .f_c1      (flag_v[1])
);

// File: tb/frt_timer_tb.sv
module frt_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       oc1_pin, oc2_pin;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  frt_timer #(.DATA_W(8), .CNT_RST(16'hFFC0)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .oc1_pin   (oc1_pin),
    .oc2_pin   (oc2_pin)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // each bus operation starts just after a falling edge and spans one rising edge
  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v, h, c0;
    logic [15:0] t;
    int          d;
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // reset state
    rd(4'h1, v); chk("R1 mode reset", v, 8'h00);
    rd(4'h2, v); chk("R3 status reset", v, 8'h00);
    rd(4'h0, v); chk("R9 level reset", v, 8'h00);
    rd(4'h7, v); chk("R5 cmp1 reset hi", v, 8'hFF);
    rd(4'h5, v); chk("R4 counter start hi", v, 8'hFF);
    rd(4'h6, v);
    chk("R9 pin1 reset", oc1_pin, 0);
    chk("R9 pin2 reset", oc2_pin, 0);
    wr(4'h2, 8'hFF);
    rd(4'h2, v); chk("R3 status ignores write", v, 8'h00);

    // rollover and matches at FFFFh, clear handshake
    idle(300);
    rd(4'h4, v);                       // unarmed access
    rd(4'h2, v); chk("R6 unarmed access keeps flags / R4 R5 set", v, 8'h68);
    rd(4'h6, v);
    rd(4'h2, v); chk("R7 quiet low read keeps overflow", v, 8'h68);
    rd(4'h4, v);
    rd(4'h2, v); chk("R6 overflow cleared by counter low", v, 8'h48);
    wr(4'hA, 8'hFF);                   // wrong low byte for channel 1? no: clears channel 2
    rd(4'h2, v); chk("R6 channel-2 cleared, channel-1 kept", v, 8'h40);
    wr(4'h8, 8'hFF);
    rd(4'h2, v); chk("R6 channel-1 cleared", v, 8'h00);

    // mode register layout
    wr(4'h1, 8'hFF);
    rd(4'h1, v); chk("R1 reserved bits read zero", v, 8'hCC);
    wr(4'h1, 8'h00);

    // stopped mode
    wr(4'h1, 8'h0C);
    rd(4'h6, c0);
    idle(40);
    rd(4'h6, v); chk("R2 select 11 holds counter", v, c0);

    // prescale sweep
    for (int s = 0; s < 3; s++) begin
      d = (s == 0) ? 4 : (s == 1) ? 2 : 8;
      for (int k = 0; k < 18; k++) begin
        wr(4'h1, 8'h0C);
        rd(4'h6, c0);
        wr(4'h1, 8'(s << 2));
        idle(k);
        rd(4'h6, v);
        chk($sformatf("R2 select %0d after %0d clocks", s, k), v, 8'(c0 + k / d));
      end
    end

    // snapshot on high read
    wr(4'h1, 8'h0C);
    rd(4'h6, c0);
    wr(4'h1, 8'h04);
    rd(4'h3, h);
    idle(9);
    rd(4'h4, v); chk("R8 low byte from snapshot", v, c0);
    rd(4'h6, v); chk("R8 live after snapshot consumed", v, 8'(c0 + 5));

    // compare channel 1 with pin disabled, then enabled
    wr(4'h1, 8'h0C);
    rd(4'h5, h); rd(4'h6, v);
    t = {h, v} + 16'd5;
    wr(4'h7, t[15:8]); wr(4'h8, t[7:0]);
    wr(4'h0, 8'h01);
    wr(4'h1, 8'h04);
    idle(20);
    chk("R10 pin off while disabled", oc1_pin, 0);
    wr(4'h8, t[7:0]);                  // unarmed access
    rd(4'h2, v); chk("R5 match flag set with pin disabled", v, 8'h40);
    wr(4'h1, 8'h84);
    chk("R10 pin shows level when enabled", oc1_pin, 1);
    chk("R9 level taken from level bit", oc1_pin, 1);
    rd(4'hA, v);
    rd(4'h2, v); chk("R6 other low byte does not clear", v, 8'h40);
    rd(4'h8, v);
    rd(4'h2, v); chk("R6 channel-1 low read clears", v, 8'h00);

    // new level bits on both channels
    wr(4'h1, 8'hCC);
    rd(4'h5, h); rd(4'h6, v);
    t = {h, v} + 16'd3;
    wr(4'h7, t[15:8]); wr(4'h8, t[7:0]);
    wr(4'h9, t[15:8]); wr(4'hA, t[7:0]);
    wr(4'h0, 8'h02);
    wr(4'h1, 8'hC4);
    idle(10);
    chk("R9 channel-1 level now 0", oc1_pin, 0);
    chk("R9 channel-2 level now 1", oc2_pin, 1);
    rd(4'h2, v); chk("R5 both match flags", v, 8'h48);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule